// File: doc/BRIEF.md
# Sparse-Addressed Microcode Sequencer

This block produces the control-store address for a small microprogrammed processor and returns the control word found at that address. Each instruction owns a slot of sixteen consecutive microwords inside a 4096-word control store. The slot is picked by two inputs. One is a raw 4-bit field of the fetched instruction, used with no decoding. The other is a 4-bit routine code from an external instruction decoder. Inside the slot, a 4-bit step counter walks through the routine.

A routine ends through the end flags in its own microwords, and these can depend on the datapath zero flag. The fetch flag also ends a routine. When a routine ends, the next clock loads a new slot from the instruction field and decoder code presented at that time, and the step counter returns to zero. A routine that runs off the end of its slot stops at the last step and raises a sticky error. It never spills into the neighbouring slot. The control store is a computed table inside the block, and every location that holds no microword reads as zero.

Top module: `microSequencer`

## Requirements
- R1: On a reload, address bits 11:8 take `instrField` unchanged and address bits 7:4 take `decodeCode`, both sampled at the reloading clock edge.
- R2: While `rst` is high at a rising edge (synchronous, active high), the address becomes 0x000 and `stepErr` clears. The fetch microword at 0x000 then appears on `ctrlWord`.
- R3: A microword with the fetch flag set causes a reload on the next edge, and the step bits 3:0 become 0.
- R4: A microword with the end-if-zero flag ends the routine (reload, step 0) when `zeroFlag` is 1. When `zeroFlag` is 0, the step advances by one.
- R5: A microword with the end-if-nonzero flag ends the routine when `zeroFlag` is 0. When `zeroFlag` is 1, the step advances by one. A word with both end flags ends the routine unconditionally.
- R6: While no reload occurs, address bits 11:4 stay constant whatever `instrField` and `decodeCode` do, and the step increments by one per clock.
- R7: At step 15 with no end condition, the address holds at step 15, and `stepErr` rises on that same edge.
- R8: Once `stepErr` is set, it stays set until reset.
- R9: The `ctrlWord` bit layout is as follows. [22:19] ALU op, [18:16] write-register select, [15:13] read-register select, [12] read enable, [11] register write, [10] memory write, [9] memory read, [8] PC write, [7] MAR write, [6:3] bus-A source, [2] fetch, [1] end-if-zero, [0] end-if-nonzero. The store holds these words: 0x000=0x00030C, 0x320=0x000090, 0x321=0x30B000, 0x322=0x030802, 0x323=0x000401, 0x324=0x000003, 0x5A0=0x000103.
- R10: Every other control-store location reads as 0x000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrField | input | 4 | Raw opcode field of the next instruction |
| decodeCode | input | 4 | Routine code from the instruction decoder |
| zeroFlag | input | 1 | Datapath zero flag for conditional ends |
| uAddr | output | 12 | Current control-store address |
| ctrlWord | output | 23 | Microword at the current address |
| stepErr | output | 1 | Sticky flag for a routine that overran its slot |

## Verification
The assertions assume that `zeroFlag`, `instrField` and `decodeCode` have known values at every rising edge, and that reset is held high from time zero for at least one edge. The bench follows these assumptions in two ways. It drives every input only on the falling edge, and it sets all three inputs to defined values before releasing reset. It then steers routines down both the ending and the continuing branch of each conditional end flag. It also drives an empty slot all the way to the saturation point.

// File: rtl/uSeqPkg.sv
package uSeqPkg;
  localparam int CW_W = 23;

  // Control word; field order fixes the bit layout seen at ctrlWord
  typedef struct packed {
    logic [3:0] aluOp;
    logic [2:0] wrSel;
    logic [2:0] rdSel;
    logic       rdEn;
    logic       regWr;
    logic       memWr;
    logic       memRd;
    logic       pcWr;
    logic       marWr;
    logic [3:0] busA;
    logic       fetch;
    logic       endZ;
    logic       endNz;
  } microWordT;

  // Strobes from sequencing control to the address datapath
  typedef struct packed {
    logic reload;
    logic hold;
  } seqStrobeT;
endpackage

// File: rtl/uCtrlStore.sv
module uCtrlStore
  import uSeqPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output microWordT         word
);
  // Sparse store: only a few locations are programmed, all others are zero
  always_comb begin
    word = '0;
    case (addr)
      ADDR_W'(12'h000): begin // instruction fetch
        word.memRd = 1'b1; word.pcWr = 1'b1; word.busA = 4'd1; word.fetch = 1'b1;
      end
      ADDR_W'(12'h320): begin
        word.marWr = 1'b1; word.busA = 4'd2;
      end
      ADDR_W'(12'h321): begin
        word.aluOp = 4'd6; word.rdSel = 3'd5; word.rdEn = 1'b1;
      end
      ADDR_W'(12'h322): begin
        word.regWr = 1'b1; word.wrSel = 3'd3; word.endZ = 1'b1;
      end
      ADDR_W'(12'h323): begin
        word.memWr = 1'b1; word.endNz = 1'b1;
      end
      ADDR_W'(12'h324): begin
        word.endZ = 1'b1; word.endNz = 1'b1;
      end
      ADDR_W'(12'h5A0): begin
        word.pcWr = 1'b1; word.endZ = 1'b1; word.endNz = 1'b1;
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/uSeqCtrl.sv
module uSeqCtrl
  import uSeqPkg::*;
#(
  parameter int STEP_W = 4
) (
  input  microWordT         word,
  input  logic              zeroFlag,
  input  logic [STEP_W-1:0] stepCnt,
  output seqStrobeT         strb
);
  logic endNow;

  always_comb begin
    endNow      = (word.endZ & zeroFlag) | (word.endNz & ~zeroFlag);
    strb.reload = endNow | word.fetch;
    strb.hold   = ~strb.reload & (stepCnt == '1);
  end
endmodule

// File: rtl/uAddrPath.sv
module uAddrPath
  import uSeqPkg::*;
#(
  parameter int OP_W   = 4,
  parameter int CODE_W = 4,
  parameter int STEP_W = 4,
  localparam int BASE_W = OP_W + CODE_W,
  localparam int ADDR_W = BASE_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   instrField,
  input  logic [CODE_W-1:0] decodeCode,
  input  seqStrobeT         strb,
  output logic [STEP_W-1:0] stepCnt,
  output logic [ADDR_W-1:0] uAddr,
  output logic              stepErr
);
  logic [BASE_W-1:0] baseReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg <= '0;
      stepCnt <= '0;
      stepErr <= 1'b0;
    end else if (strb.reload) begin
      baseReg <= {instrField, decodeCode};
      stepCnt <= '0;
    end else if (strb.hold) begin
      stepErr <= 1'b1;
    end else begin
      stepCnt <= stepCnt + STEP_W'(1);
    end
  end

  assign uAddr = {baseReg, stepCnt};

  p_reset_r2: assert property (@(posedge clk) rst |=> (uAddr == '0 && !stepErr));
  p_reload_r1: assert property (@(posedge clk) disable iff (rst)
    strb.reload |=> (uAddr[ADDR_W-1:STEP_W] == $past({instrField, decodeCode})));
  p_step_clear_r3: assert property (@(posedge clk) disable iff (rst)
    strb.reload |=> (stepCnt == '0));
  p_base_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.reload |=> $stable(baseReg));
  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (!strb.reload && stepCnt != '1) |=> (stepCnt == STEP_W'($past(stepCnt) + 1'b1)));
  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (!strb.reload && stepCnt == '1) |=> (stepCnt == '1 && stepErr));
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    stepErr |=> stepErr);
endmodule

// File: rtl/microSequencer.sv
module microSequencer
  import uSeqPkg::*;
#(
  parameter int OP_W   = 4,
  parameter int CODE_W = 4,
  parameter int STEP_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [OP_W-1:0]                  instrField,
  input  logic [CODE_W-1:0]                decodeCode,
  input  logic                             zeroFlag,
  output logic [OP_W+CODE_W+STEP_W-1:0]    uAddr,
  output logic [CW_W-1:0]                  ctrlWord,
  output logic                             stepErr
);
  localparam int ADDR_W = OP_W + CODE_W + STEP_W;

  microWordT         curWord;
  seqStrobeT         strb;
  logic [STEP_W-1:0] stepCnt;

  uCtrlStore #(.ADDR_W(ADDR_W)) i_store (
    .addr(uAddr),
    .word(curWord)
  );

  uSeqCtrl #(.STEP_W(STEP_W)) i_ctrl (
    .word    (curWord),
    .zeroFlag(zeroFlag),
    .stepCnt (stepCnt),
    .strb    (strb)
  );

  uAddrPath #(.OP_W(OP_W), .CODE_W(CODE_W), .STEP_W(STEP_W)) i_path (
    .clk       (clk),
    .rst       (rst),
    .instrField(instrField),
    .decodeCode(decodeCode),
    .strb      (strb),
    .stepCnt   (stepCnt),
    .uAddr     (uAddr),
    .stepErr   (stepErr)
  );

  assign ctrlWord = curWord;
endmodule

// File: tb/test_microSequencer.sv
module test_microSequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  instrField = 4'd0;
  logic [3:0]  decodeCode = 4'd0;
  logic        zeroFlag = 1'b0;
  logic [11:0] uAddr;
  logic [22:0] ctrlWord;
  logic        stepErr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  microSequencer i_microSequencer (
    .clk(clk), .rst(rst), .instrField(instrField), .decodeCode(decodeCode),
    .zeroFlag(zeroFlag), .uAddr(uAddr), .ctrlWord(ctrlWord), .stepErr(stepErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // advance one clock; inputs change and outputs are sampled on the falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick(); tick();
    check("R2 addr", 32'(uAddr), 32'h000);
    check("R2 err", 32'(stepErr), 0);
    check("R2 fetch word", 32'(ctrlWord), 32'h00030C);
    rst = 1'b0;
  endtask

  task automatic fetchInto(input logic [3:0] op, input logic [3:0] code);
    instrField = op; decodeCode = code;
    tick();
    check("R3 step cleared after fetch", 32'(uAddr[3:0]), 0);
    check("R1 slot from instr and code", 32'(uAddr[11:4]), 32'({op, code}));
  endtask

  task automatic routineEndOnZero();
    fetchInto(4'h3, 4'h2);
    check("R9 word 0x320", 32'(ctrlWord), 32'h000090);
    instrField = 4'hC; decodeCode = 4'h9; // must be ignored mid-routine
    tick();
    check("R6 step advance", 32'(uAddr), 32'h321);
    check("R9 word 0x321", 32'(ctrlWord), 32'h30B000);
    tick();
    check("R6 base held", 32'(uAddr), 32'h322);
    check("R9 word 0x322", 32'(ctrlWord), 32'h030802);
    zeroFlag = 1'b1; instrField = 4'h0; decodeCode = 4'h0;
    tick();
    check("R4 end on zero", 32'(uAddr), 32'h000);
  endtask

  task automatic routineNonzeroPaths();
    zeroFlag = 1'b0;
    fetchInto(4'h3, 4'h2);
    tick(); tick();
    check("R4 at end-if-zero word", 32'(uAddr), 32'h322);
    zeroFlag = 1'b0;
    tick();
    check("R4 no end when zero clear", 32'(uAddr), 32'h323);
    check("R9 word 0x323", 32'(ctrlWord), 32'h000401);
    zeroFlag = 1'b0; instrField = 4'h5; decodeCode = 4'hA;
    tick();
    check("R5 end on nonzero", 32'(uAddr), 32'h5A0);
    check("R9 word 0x5A0", 32'(ctrlWord), 32'h000103);
    zeroFlag = 1'b1; instrField = 4'h0; decodeCode = 4'h0;
    tick();
    check("R5 unconditional end", 32'(uAddr), 32'h000);
  endtask

  task automatic routineNonzeroContinue();
    zeroFlag = 1'b0;
    fetchInto(4'h3, 4'h2);
    tick(); tick();
    zeroFlag = 1'b0;
    tick();
    check("R5 reach 0x323", 32'(uAddr), 32'h323);
    zeroFlag = 1'b1;
    tick();
    check("R5 no end when zero set", 32'(uAddr), 32'h324);
    check("R9 word 0x324", 32'(ctrlWord), 32'h000003);
    instrField = 4'h7; decodeCode = 4'hF; zeroFlag = 1'b0;
    tick();
    check("R5 both flags end", 32'(uAddr), 32'h7F0);
    check("R10 empty slot word", 32'(ctrlWord), 0);
  endtask

  task automatic overrun();
    for (int s = 1; s <= 15; s++) begin
      instrField = 4'(s); decodeCode = 4'(~s);
      zeroFlag = s[0];
      tick();
      check("R6 step in empty slot", 32'(uAddr), 32'h7F0 + 32'(s));
      check("R10 unused reads zero", 32'(ctrlWord), 0);
      check("R7 no error before overrun", 32'(stepErr), 0);
    end
    tick();
    check("R7 hold at step 15", 32'(uAddr), 32'h7FF);
    check("R7 error raised", 32'(stepErr), 1);
    tick(); tick();
    check("R8 error sticky", 32'(stepErr), 1);
    check("R7 still held", 32'(uAddr), 32'h7FF);
    doReset();
    check("R8 reset clears error", 32'(stepErr), 0);
  endtask

  initial begin
    tick();
    doReset();
    routineEndOnZero();
    routineNonzeroPaths();
    routineNonzeroContinue();
    overrun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule